// File: doc/BRIEF.md
# Transmit Buffer Priority Arbiter

This block holds sixteen message-buffer descriptors (a 4-bit code, a 29-bit identifier and a frame-type bit each) and picks the transmit buffer that the CAN engine sends next. A buffer competes only while its code requests transmission. A mode input chooses the rule. In identifier mode the lowest aligned identifier wins. In position mode the lowest buffer index wins. The result is offered as a valid flag plus an index and stays up until the engine reports completion or software touches that buffer.

Software writes a whole descriptor through one write port. Any such write also counts as an access to the buffer's control/status field. That access pulls the buffer out of the arbitration run in progress, and it rejoins at the next run. A completion pulse retires the offered buffer by rewriting its code to the transmit-idle value. A read port returns any buffer's current code.

A three-state machine sequences the work:
- `ST_IDLE` lasts one cycle. It clears the exclusion set and the best candidate, latches the mode, and always moves to `ST_SCAN`.
- `ST_SCAN` examines one buffer per clock, from index 0 to 15. After index 15 it moves to `ST_OFFER` if a surviving candidate exists. Otherwise it returns to `ST_IDLE`.
- `ST_OFFER` drives the valid output. It returns to `ST_IDLE` on a completion pulse (retire) or on a write to the offered buffer (withdraw).

Top module: `txbuf_arbiter`

## Requirements
- R1: After reset every buffer code reads as 4'b0000 and `win_valid` is low.
- R2: Only a buffer whose code is 4'b1100 (transmit request) can be offered. Codes 4'b1000, 4'b0000 and any other value never compete. When no buffer holds 4'b1100, `win_valid` stays low.
- R3: With `by_index` low, the lowest 29-bit key wins. A standard frame (`wr_ext`=0) has the key {id[28:18], 18'b0`}`, so its lower 18 identifier bits are ignored. An extended frame (`wr_ext`=1) uses all 29 bits. On equal keys a standard frame beats an extended one, and after that the lower index wins.
- R4: With `by_index` high, the lowest-indexed buffer holding 4'b1100 wins, whatever its identifier.
- R5: A completion or withdrawal clears `win_valid` on the next cycle. With no further writes, the next result is presented exactly 17 cycles after that edge: one idle cycle plus sixteen scan cycles.
- R6: While offered, `win_valid` and `win_idx` stay stable until a completion pulse or a write to the offered buffer.
- R7: A `tx_done` pulse while offering rewrites the winner's code to 4'b1000 and drops `win_valid`.
- R8: A write to the offered buffer withdraws the offer on the next cycle.
- R9: A write during a scan excludes that buffer from the current run, and the buffer competes again in the next run. If the excluded buffer was the run's best candidate, the run ends with no offer.
- R10: If `tx_done` and a write to the winner fall in the same cycle, the written code is kept and no 4'b1000 is stored. If the write targets another buffer, both updates take effect.
- R11: A write stores code, identifier and type at `wr_idx`. `rd_code` returns the code of buffer `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| by_index | input | 1 | 1: lowest index wins; 0: lowest identifier wins |
| wr_en | input | 1 | Descriptor write strobe (also a control/status access) |
| wr_idx | input | 4 | Buffer written |
| wr_code | input | 4 | New code |
| wr_id | input | 29 | New identifier (standard ID in bits 28:18) |
| wr_ext | input | 1 | 1: extended frame, 0: standard frame |
| tx_done | input | 1 | Transmission-complete pulse for the offered buffer |
| rd_idx | input | 4 | Buffer whose code is read |
| win_valid | output | 1 | A winner is being offered |
| win_idx | output | 4 | Index of the offered buffer |
| rd_code | output | 4 | Code of buffer `rd_idx` |

## Verification
The completion pulse and a software write can land in the same cycle. When both target the winner they contend for that buffer's code. The bench drives `tx_done` together with a write to the offered buffer, then reads the code back and expects the written value rather than 4'b1000. It repeats the pairing with the write aimed at another buffer, where it expects both updates and a following run that picks the newly written buffer. A write timed to land on a buffer's own scan cycle is also judged, by which buffer the run then offers.

// File: rtl/txarb_pkg.sv
package txarb_pkg;

    localparam logic [3:0] CODE_RX_OFF = 4'b0000;
    localparam logic [3:0] CODE_TX_OFF = 4'b1000;
    localparam logic [3:0] CODE_TX_REQ = 4'b1100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_OFFER = 2'd2
    } arb_state_e;

endpackage

// File: rtl/txarb_store.sv
module txarb_store
    import txarb_pkg::*;
#(
    parameter int NBUF = 16,
    parameter int IDW  = 29,
    parameter int STDW = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NBUF)-1:0]   wr_idx,
    input  logic [3:0]                wr_code,
    input  logic [IDW-1:0]            wr_id,
    input  logic                      wr_ext,
    input  logic                      clr_en,
    input  logic [$clog2(NBUF)-1:0]   clr_idx,
    input  logic [$clog2(NBUF)-1:0]   scan_idx,
    input  logic [$clog2(NBUF)-1:0]   rd_idx,
    output logic [3:0]                scan_code,
    output logic [IDW-1:0]            scan_key,
    output logic                      scan_ext,
    output logic [3:0]                rd_code,
    output logic [NBUF*4-1:0]         code_flat
);

    localparam int LOW_W = IDW - STDW;

    logic [IDW-1:0] wr_key;
    logic [3:0]     code_q [NBUF];
    logic [IDW-1:0] key_q  [NBUF];
    logic           ext_q  [NBUF];

    // Standard identifiers sit in the top bits; their low bits do not rank.
    assign wr_key = wr_ext ? wr_id : {wr_id[IDW-1 -: STDW], {LOW_W{1'b0}}};

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic sel_wr;
        logic sel_clr;
        assign sel_wr  = wr_en  && (wr_idx  == g[$clog2(NBUF)-1:0]);
        assign sel_clr = clr_en && (clr_idx == g[$clog2(NBUF)-1:0]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[g] <= CODE_RX_OFF;
                key_q[g]  <= '0;
                ext_q[g]  <= 1'b0;
            end else if (sel_wr) begin
                code_q[g] <= wr_code;
                key_q[g]  <= wr_key;
                ext_q[g]  <= wr_ext;
            end else if (sel_clr) begin
                code_q[g] <= CODE_TX_OFF;
            end
        end

        assign code_flat[g*4 +: 4] = code_q[g];
    end

    assign scan_code = code_q[scan_idx];
    assign scan_key  = key_q[scan_idx];
    assign scan_ext  = ext_q[scan_idx];
    assign rd_code   = code_q[rd_idx];

endmodule

// File: rtl/txarb_rank.sv
module txarb_rank #(
    parameter int IDW = 29
) (
    input  logic           by_index,
    input  logic           best_vld,
    input  logic [IDW-1:0] best_key,
    input  logic           best_ext,
    input  logic           cand_ok,
    input  logic [IDW-1:0] cand_key,
    input  logic           cand_ext,
    output logic           take
);

    logic key_lt;
    logic key_eq;
    logic id_better;

    assign key_lt    = cand_key < best_key;
    assign key_eq    = cand_key == best_key;
    // Scan runs upward, so a tie that gets this far keeps the lower index.
    assign id_better = key_lt || (key_eq && !cand_ext && best_ext);

    always_comb begin
        take = 1'b0;
        if (cand_ok) begin
            if (!best_vld) take = 1'b1;
            else if (!by_index) take = id_better;
        end
    end

endmodule

// File: rtl/txarb_seq.sv
module txarb_seq
    import txarb_pkg::*;
#(
    parameter int NBUF = 16,
    parameter int IDW  = 29
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      by_index,
    input  logic                      wr_en,
    input  logic [$clog2(NBUF)-1:0]   wr_idx,
    input  logic                      tx_done,
    input  logic [3:0]                scan_code,
    input  logic [IDW-1:0]            scan_key,
    input  logic                      scan_ext,
    output logic [$clog2(NBUF)-1:0]   scan_idx,
    output logic                      clr_en,
    output logic [$clog2(NBUF)-1:0]   clr_idx,
    output logic                      win_valid,
    output logic [$clog2(NBUF)-1:0]   win_idx
);

    localparam int IW = $clog2(NBUF);

    arb_state_e     state_q, state_d;
    logic [IW-1:0]  ptr_q;
    logic [NBUF-1:0] excl_q;
    logic           mode_q;
    logic           bvld_q;
    logic [IW-1:0]  bidx_q;
    logic [IDW-1:0] bkey_q;
    logic           bext_q;

    logic [NBUF-1:0] wr_hot;
    logic [NBUF-1:0] excl_now;
    logic            cand_ok;
    logic            take;
    logic            nbvld;
    logic [IW-1:0]   nbidx;
    logic            last_slot;
    logic            run_ok;
    logic            hit_win;

    assign wr_hot    = wr_en ? ({{(NBUF-1){1'b0}}, 1'b1} << wr_idx) : '0;
    assign excl_now  = excl_q | wr_hot;
    assign cand_ok   = (state_q == ST_SCAN) && (scan_code == CODE_TX_REQ)
                       && !excl_now[ptr_q];
    assign nbvld     = bvld_q | take;
    assign nbidx     = take ? ptr_q : bidx_q;
    assign last_slot = ptr_q == IW'(NBUF - 1);
    assign run_ok    = nbvld && !excl_now[nbidx];
    assign hit_win   = wr_en && (wr_idx == bidx_q);

    txarb_rank #(.IDW(IDW)) u_rank (
        .by_index (mode_q),
        .best_vld (bvld_q),
        .best_key (bkey_q),
        .best_ext (bext_q),
        .cand_ok  (cand_ok),
        .cand_key (scan_key),
        .cand_ext (scan_ext),
        .take     (take)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_SCAN;
            ST_SCAN:  if (last_slot) state_d = run_ok ? ST_OFFER : ST_IDLE;
            ST_OFFER: if (hit_win || tx_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Run bookkeeping: pointer, exclusions, best candidate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            excl_q <= '0;
            mode_q <= 1'b0;
            bvld_q <= 1'b0;
            bidx_q <= '0;
            bkey_q <= '0;
            bext_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    ptr_q  <= '0;
                    excl_q <= '0;
                    bvld_q <= 1'b0;
                    mode_q <= by_index;
                end
                ST_SCAN: begin
                    ptr_q  <= ptr_q + 1'b1;
                    excl_q <= excl_now;
                    bvld_q <= nbvld;
                    if (take) begin
                        bidx_q <= ptr_q;
                        bkey_q <= scan_key;
                        bext_q <= scan_ext;
                    end
                end
                ST_OFFER: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        win_valid = state_q == ST_OFFER;
        win_idx   = bidx_q;
        clr_en    = (state_q == ST_OFFER) && tx_done && !hit_win;
        clr_idx   = bidx_q;
        scan_idx  = ptr_q;
    end

endmodule

// File: rtl/txbuf_arbiter.sv
module txbuf_arbiter #(
    parameter int NBUF = 16,
    parameter int IDW  = 29,
    parameter int STDW = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      by_index,
    input  logic                      wr_en,
    input  logic [$clog2(NBUF)-1:0]   wr_idx,
    input  logic [3:0]                wr_code,
    input  logic [IDW-1:0]            wr_id,
    input  logic                      wr_ext,
    input  logic                      tx_done,
    input  logic [$clog2(NBUF)-1:0]   rd_idx,
    output logic                      win_valid,
    output logic [$clog2(NBUF)-1:0]   win_idx,
    output logic [3:0]                rd_code
);

    localparam int IW = $clog2(NBUF);

    logic [IW-1:0]    scan_idx;
    logic [3:0]       scan_code;
    logic [IDW-1:0]   scan_key;
    logic             scan_ext;
    logic             clr_en;
    logic [IW-1:0]    clr_idx;
    logic [NBUF*4-1:0] code_flat;

    txarb_store #(.NBUF(NBUF), .IDW(IDW), .STDW(STDW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_code   (wr_code),
        .wr_id     (wr_id),
        .wr_ext    (wr_ext),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .scan_idx  (scan_idx),
        .rd_idx    (rd_idx),
        .scan_code (scan_code),
        .scan_key  (scan_key),
        .scan_ext  (scan_ext),
        .rd_code   (rd_code),
        .code_flat (code_flat)
    );

    txarb_seq #(.NBUF(NBUF), .IDW(IDW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .by_index  (by_index),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .tx_done   (tx_done),
        .scan_code (scan_code),
        .scan_key  (scan_key),
        .scan_ext  (scan_ext),
        .scan_idx  (scan_idx),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

endmodule

// File: rtl/txarb_checker.sv
module txarb_checker #(
    parameter int NBUF = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [$clog2(NBUF)-1:0] wr_idx,
    input logic [3:0]              wr_code,
    input logic                    tx_done,
    input logic                    win_valid,
    input logic [$clog2(NBUF)-1:0] win_idx,
    input logic [NBUF*4-1:0]       code_flat
);

    localparam int IW = $clog2(NBUF);

    logic          hit;
    logic [IW-1:0] prev_idx;
    logic [3:0]    prev_wcode;

    assign hit = wr_en && (wr_idx == win_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_idx   <= '0;
            prev_wcode <= '0;
        end else begin
            prev_idx   <= win_idx;
            prev_wcode <= wr_code;
        end
    end

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !hit && !tx_done) |=> (win_valid && win_idx == prev_idx)); // R6
    AST_WITHDRAW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && hit) |=> !win_valid); // R8
    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && tx_done && !hit) |=> (!win_valid && code_flat[{prev_idx, 2'b00} +: 4] == 4'b1000)); // R7
    AST_WRITE_BEATS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && tx_done && hit) |=> (code_flat[{prev_idx, 2'b00} +: 4] == prev_wcode)); // R10
    AST_OFFER_IS_TXREQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_valid) |-> (code_flat[{win_idx, 2'b00} +: 4] == 4'b1100)); // R2

endmodule

bind txbuf_arbiter txarb_checker #(.NBUF(NBUF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_code   (wr_code),
    .tx_done   (tx_done),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .code_flat (code_flat)
);

// File: tb/sim_txbuf_arbiter.sv
`timescale 1ns/1ps
module sim_txbuf_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        by_index;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [3:0]  wr_code;
    logic [28:0] wr_id;
    logic        wr_ext;
    logic        tx_done;
    logic [3:0]  rd_idx;
    logic        win_valid;
    logic [3:0]  win_idx;
    logic [3:0]  rd_code;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    logic [3:0]  m_code [16];
    logic [28:0] m_id   [16];
    logic        m_ext  [16];

    always #5 clk = ~clk;

    txbuf_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .by_index(by_index), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_code(wr_code), .wr_id(wr_id), .wr_ext(wr_ext),
        .tx_done(tx_done), .rd_idx(rd_idx), .win_valid(win_valid),
        .win_idx(win_idx), .rd_code(rd_code)
    );

    function automatic logic [28:0] keyof(logic [28:0] id, logic ext);
        return ext ? id : {id[28:18], 18'b0};
    endfunction

    function automatic int exp_win(bit byi);
        int w = -1;
        for (int i = 0; i < 16; i++) begin
            if (m_code[i] == 4'b1100) begin
                if (w < 0) w = i;
                else if (!byi && (keyof(m_id[i], m_ext[i]) < keyof(m_id[w], m_ext[w]) ||
                         (keyof(m_id[i], m_ext[i]) == keyof(m_id[w], m_ext[w]) &&
                          !m_ext[i] && m_ext[w]))) w = i;
            end
        end
        return w;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic set_m(int i, logic [3:0] c, logic [28:0] id, logic e);
        m_code[i] = c; m_id[i] = id; m_ext[i] = e;
    endtask

    task automatic wr(int i, logic [3:0] c, logic [28:0] id, logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(i); wr_code = c; wr_id = id; wr_ext = e;
        set_m(i, c, id, e);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; tx_done = 1'b0;
    endtask

    task automatic load_all();
        for (int i = 0; i < 16; i++) wr(i, m_code[i], m_id[i], m_ext[i]);
        idle();
    endtask

    task automatic read_code(int i, output logic [3:0] c);
        rd_idx = 4'(i);
        #1 c = rd_code;
    endtask

    task automatic wait_result(int e, string req);
        repeat (16) @(negedge clk);
        chk(win_valid == 1'b0, "R5", win_valid, 0);
        @(negedge clk);
        if (e < 0) chk(win_valid == 1'b0, "R2", win_valid, 0);
        else begin
            chk(win_valid == 1'b1, "R5", win_valid, 1);
            chk(int'(win_idx) == e, req, win_idx, e);
        end
    endtask

    // Load the model into the design and bring up a run free of writes.
    task automatic clean_offer(bit byi, output int e);
        int got = 0;
        int w;
        @(negedge clk) by_index = byi;
        load_all();
        e = exp_win(byi);
        for (int t = 0; t < 60 && got == 0; t++) begin
            @(negedge clk);
            if (win_valid) got = 1;
        end
        if (e < 0) begin
            chk(got == 0, "R2", got, 0);
            return;
        end
        chk(got == 1, "R2", got, 1);
        if (got == 0) return;
        w = win_idx;
        wr(w, m_code[w], m_id[w], m_ext[w]);
        idle();
        chk(win_valid == 1'b0, "R8", win_valid, 0);
        wait_result(e, byi ? "R4" : "R3");
    endtask

    task automatic done_pulse();
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
    endtask

    task automatic arb_round(bit byi);
        int e;
        logic [3:0] c;
        clean_offer(byi, e);
        if (e < 0) return;
        repeat (3) @(negedge clk);
        chk(win_valid && int'(win_idx) == e, "R6", win_idx, e);
        done_pulse();
        chk(win_valid == 1'b0, "R7", win_valid, 0);
        read_code(e, c);
        chk(c == 4'b1000, "R7", c, 8);
        m_code[e] = 4'b1000;
        wait_result(exp_win(byi) - 0, byi ? "R4" : "R3");
    endtask

    function automatic logic [3:0] rnd_code();
        case ($urandom % 6)
            0: return 4'b0000;
            1: return 4'b1000;
            2, 3: return 4'b1100;
            4: return 4'b0100;
            default: return 4'b0110;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_err++;
            $display("FAIL watchdog R5 actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        int e;
        logic [3:0] c;
        void'($urandom(32'd4711));
        rst_n = 1'b0; by_index = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_code = '0;
        wr_id = '0; wr_ext = 1'b0; tx_done = 1'b0; rd_idx = '0;
        for (int i = 0; i < 16; i++) set_m(i, 4'b1000, 29'h0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(win_valid == 1'b0, "R1", win_valid, 0);
        for (int i = 0; i < 16; i++) begin
            read_code(i, c);
            chk(c == 4'b0000, "R1", c, 0);
        end

        // R3: equal key, standard beats extended even at a higher index
        for (int i = 0; i < 16; i++) set_m(i, 4'b1000, 29'(i), 1'b1);
        set_m(1, 4'b1100, {11'h055, 18'h0}, 1'b1);
        set_m(2, 4'b1100, {11'h055, 18'h2a5}, 1'b0);
        arb_round(1'b0);

        // R3: equal standard keys, lower index first; extended with larger key last
        for (int i = 0; i < 16; i++) set_m(i, 4'b1000, 29'(i), 1'b1);
        set_m(4, 4'b1100, {11'h010, 18'h00001}, 1'b0);
        set_m(9, 4'b1100, {11'h010, 18'h3ffff}, 1'b0);
        set_m(11, 4'b1100, {11'h010, 18'h00002}, 1'b1);
        arb_round(1'b0);

        // R4: index mode ignores identifiers
        for (int i = 0; i < 16; i++) set_m(i, 4'b1000, 29'(i), 1'b0);
        set_m(3, 4'b1100, 29'h1fffffff, 1'b1);
        set_m(8, 4'b1100, 29'h0, 1'b0);
        arb_round(1'b1);

        // R2: nothing requests transmission
        for (int i = 0; i < 16; i++) set_m(i, (i % 2 == 0) ? 4'b1000 : 4'b0100, 29'(i), 1'b0);
        arb_round(1'b0);

        // Random configurations
        for (int t = 0; t < 40; t++) begin
            int ri;
            for (int i = 0; i < 16; i++) begin
                logic e1 = 1'($urandom % 2);
                logic [28:0] id = (t % 3 == 0) ? 29'($urandom)
                                  : {11'($urandom % 4), 18'($urandom % 2)};
                set_m(i, rnd_code(), id, e1);
            end
            arb_round(1'($urandom % 2));
            ri = $urandom % 16;
            read_code(ri, c);
            chk(c == m_code[ri], "R11", c, m_code[ri]);
        end

        // R9: write landing on a buffer's own scan cycle excludes it
        for (int i = 0; i < 16; i++) set_m(i, 4'b1000, 29'h1000000 + 29'(i), 1'b1);
        set_m(6, 4'b1100, {11'd500, 18'h0}, 1'b0);
        set_m(12, 4'b1100, {11'd900, 18'h0}, 1'b0);
        clean_offer(1'b0, e);
        chk(e == 6, "R3", e, 6);
        done_pulse();
        m_code[6] = 4'b1000;
        repeat (10) @(negedge clk);
        wr(10, 4'b1100, {11'd10, 18'h0}, 1'b0);
        idle();
        repeat (5) @(negedge clk);
        chk(win_valid == 1'b1, "R9", win_valid, 1);
        chk(win_idx == 4'd12, "R9", win_idx, 12);
        wr(12, m_code[12], m_id[12], m_ext[12]);
        idle();
        wait_result(10, "R9");

        // R10: completion and a write to the winner in one cycle
        @(negedge clk);
        tx_done = 1'b1; wr_en = 1'b1; wr_idx = 4'd10; wr_code = 4'b0100;
        wr_id = m_id[10]; wr_ext = m_ext[10];
        m_code[10] = 4'b0100;
        idle();
        chk(win_valid == 1'b0, "R10", win_valid, 0);
        read_code(10, c);
        chk(c == 4'b0100, "R10", c, 4);
        wait_result(12, "R5");

        // R10: completion with a write to another buffer in one cycle
        @(negedge clk);
        tx_done = 1'b1; wr_en = 1'b1; wr_idx = 4'd1; wr_code = 4'b1100;
        wr_id = {11'd3, 18'h0}; wr_ext = 1'b0;
        set_m(1, 4'b1100, {11'd3, 18'h0}, 1'b0);
        m_code[12] = 4'b1000;
        idle();
        read_code(12, c);
        chk(c == 4'b1000, "R10", c, 8);
        read_code(1, c);
        chk(c == 4'b1100, "R11", c, 12);
        wait_result(1, "R10");

        done_flag = 1;
        summary();
    end

endmodule